// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds that drive a FIFO's programmable almost-empty and almost-full flags. Each threshold is split over two byte-wide registers, a low byte and a high byte, so the block holds four registers. They are loaded from the write data bus on write clock edges while the load strobe and the write enable are both low. Successive loads fill the registers in a fixed rotation. A load sequence may stop after any register, and the next load carries on at the register after the last one written.

With the load strobe low and both read enables low, the register contents come back out on the read data bus. Each rising edge of the read clock presents one register. Readback has its own pointer and follows the same rotation as loading.

The flags compare the FIFO core's word count against the thresholds. The almost-empty flag is registered on the read clock and the almost-full flag on the write clock. Both flags are active low. The storage array and the plain full and empty flags belong to the FIFO core, outside this block.

Top module: `pflag_offset_loader`

## Requirements
- R1: While reset is low: all four offset registers hold 7, both load and readback pointers select the empty-low register (index 0), `rd_data` is 0, `almost_full_n` is 1 and `almost_empty_n` is 0.
- R2: A write clock edge with `wr_en_n`=0 and `ld_n`=0 writes `wr_data[7:0]` into the register at the load pointer. The pointer steps in the order empty-low (0), empty-high (1), full-low (2), full-high (3), and the fifth load wraps back to empty-low.
- R3: A write clock edge where `wr_en_n` or `ld_n` is 1 changes no offset register and does not move the load pointer.
- R4: After `ld_n` is raised for any number of cycles, the next load writes the register after the last one written.
- R5: A read clock edge with `ld_n`=0, `rd_en1_n`=0 and `rd_en2_n`=0 places the register at the readback pointer on `rd_data`, zero-extended to 9 bits. The readback pointer then advances in the same order as R2 and wraps after full-high.
- R6: On a read clock edge without the full readback condition, `rd_data` keeps its value.
- R7: `wr_data[8]` is ignored on loads, so the stored byte equals `wr_data[7:0]`.
- R8: One read clock edge after `fill_count` is applied, `almost_empty_n` is 0 when `fill_count` is at most the empty threshold, and 1 otherwise.
- R9: One write clock edge after `fill_count` is applied, `almost_full_n` is 0 when `DEPTH - fill_count` is at most the full threshold, and 1 otherwise.
- R10: With DEPTH=256, each threshold is the low register alone. The values stored in the empty-high and full-high registers do not change either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; drives loads and the almost-full flag |
| rd_clk | input | 1 | Read clock; drives readback and the almost-empty flag |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Offset load/readback select, active low |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| wr_data | input | 9 | Write data bus; bits 7:0 feed the offset registers |
| fill_count | input | 9 | Current word count from the FIFO core, 0 to DEPTH |
| rd_data | output | 9 | Readback register output |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low, read clock domain |
| almost_full_n | output | 1 | Programmable almost-full flag, active low, write clock domain |

## Verification
A load pointer stuck or skipping shows up at the very next readback sweep: a value appears in the wrong slot, or an old value persists. It also shows up as a flag edge at the wrong `fill_count` one cycle after the threshold changes. A readback pointer fault shows on `rd_data` one read clock edge after the first readback. Flag compare errors are visible one clock after `fill_count` crosses a threshold, so the bench probes each threshold at the value equal to it and at one on either side.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

  // Register slots in load and readback order; the order is behaviour.
  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } ofs_slot_e;

  localparam int NUM_SLOTS = 4;

  // Rotation step shared by the load and readback pointers.
  function automatic logic [1:0] slot_next(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction

endpackage

// File: rtl/ofs_bank.sv
module ofs_bank
  import pflag_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFS_W    = 8,
  parameter int DFLT_OFS = 7
) (
  input  logic                            wr_clk,
  input  logic                            rst_n,
  input  logic                            wr_en_n,
  input  logic                            ld_n,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_SLOTS-1:0][OFS_W-1:0] ofs_q,
  output logic [1:0]                      wr_sel,
  output logic                            load_fire
);

  logic [OFS_W-1:0] load_byte;

  assign load_fire = !wr_en_n && !ld_n;
  assign load_byte = wr_data[OFS_W-1:0];

  generate
    if (DATA_W > OFS_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
    end
  endgenerate

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n)         wr_sel <= SLOT_E_LO;
    else if (load_fire) wr_sel <= slot_next(wr_sel);
  end

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = load_fire && (wr_sel == 2'(s));
      always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n)   ofs_q[s] <= OFS_W'(DFLT_OFS);
        else if (hit) ofs_q[s] <= load_byte;
      end
    end
  endgenerate

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import pflag_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 8
) (
  input  logic                            rd_clk,
  input  logic                            rst_n,
  input  logic                            ld_n,
  input  logic                            rd_en1_n,
  input  logic                            rd_en2_n,
  input  logic [NUM_SLOTS-1:0][OFS_W-1:0] ofs_q,
  output logic [DATA_W-1:0]               rd_data,
  output logic [1:0]                      rd_sel,
  output logic                            rb_fire
);

  assign rb_fire = !ld_n && !rd_en1_n && !rd_en2_n;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel  <= SLOT_E_LO;
      rd_data <= '0;
    end else if (rb_fire) begin
      rd_sel  <= slot_next(rd_sel);
      rd_data <= DATA_W'(ofs_q[rd_sel]);
    end
  end

endmodule

// File: rtl/pflag_cmp.sv
module pflag_cmp
  import pflag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFS_W = 8,
  parameter int CNT_W = 9
) (
  input  logic                            wr_clk,
  input  logic                            rd_clk,
  input  logic                            rst_n,
  input  logic [CNT_W-1:0]                fill_count,
  input  logic [NUM_SLOTS-1:0][OFS_W-1:0] ofs_q,
  output logic                            ae_hit,
  output logic                            af_hit,
  output logic                            almost_empty_n,
  output logic                            almost_full_n
);

  localparam int LVL_W = $clog2(DEPTH);

  logic [CNT_W-1:0] e_thr;
  logic [CNT_W-1:0] f_thr;

  // Fill level at or below the empty threshold.
  function automatic logic fill_le(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] thr);
    return cnt <= thr;
  endfunction

  // Free space at or below the full threshold.
  function automatic logic space_le(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] thr);
    logic [CNT_W-1:0] space;
    space = CNT_W'(DEPTH) - cnt;
    return space <= thr;
  endfunction

  generate
    if (LVL_W <= OFS_W) begin : g_low_only
      logic cmp_unused;
      assign cmp_unused = ^ofs_q;
      assign e_thr = CNT_W'(ofs_q[SLOT_E_LO][LVL_W-1:0]);
      assign f_thr = CNT_W'(ofs_q[SLOT_F_LO][LVL_W-1:0]);
    end else begin : g_wide
      assign e_thr = CNT_W'({ofs_q[SLOT_E_HI][LVL_W-OFS_W-1:0], ofs_q[SLOT_E_LO]});
      assign f_thr = CNT_W'({ofs_q[SLOT_F_HI][LVL_W-OFS_W-1:0], ofs_q[SLOT_F_LO]});
    end
  endgenerate

  assign ae_hit = fill_le(fill_count, e_thr);
  assign af_hit = space_le(fill_count, f_thr);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) almost_empty_n <= 1'b0;
    else        almost_empty_n <= !ae_hit;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) almost_full_n <= 1'b1;
    else        almost_full_n <= !af_hit;
  end

endmodule

// File: rtl/pflag_offset_loader.sv
module pflag_offset_loader
  import pflag_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 9,
  parameter int OFS_W    = 8,
  parameter int DFLT_OFS = 7
) (
  input  logic                         wr_clk,
  input  logic                         rd_clk,
  input  logic                         rst_n,
  input  logic                         wr_en_n,
  input  logic                         ld_n,
  input  logic                         rd_en1_n,
  input  logic                         rd_en2_n,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [$clog2(DEPTH+1)-1:0]   fill_count,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         almost_empty_n,
  output logic                         almost_full_n
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_SLOTS-1:0][OFS_W-1:0] ofs_q;
  logic [1:0] wr_sel;
  logic [1:0] rd_sel;
  logic       load_fire;
  logic       rb_fire;
  logic       ae_hit;
  logic       af_hit;

  ofs_bank #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DFLT_OFS(DFLT_OFS)) u_bank (
    .wr_clk   (wr_clk),
    .rst_n    (rst_n),
    .wr_en_n  (wr_en_n),
    .ld_n     (ld_n),
    .wr_data  (wr_data),
    .ofs_q    (ofs_q),
    .wr_sel   (wr_sel),
    .load_fire(load_fire)
  );

  ofs_readback #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rdbk (
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .ld_n    (ld_n),
    .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n),
    .ofs_q   (ofs_q),
    .rd_data (rd_data),
    .rd_sel  (rd_sel),
    .rb_fire (rb_fire)
  );

  pflag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cmp (
    .wr_clk        (wr_clk),
    .rd_clk        (rd_clk),
    .rst_n         (rst_n),
    .fill_count    (fill_count),
    .ofs_q         (ofs_q),
    .ae_hit        (ae_hit),
    .af_hit        (af_hit),
    .almost_empty_n(almost_empty_n),
    .almost_full_n (almost_full_n)
  );

endmodule

// File: rtl/pflag_offset_chk.sv
module pflag_offset_chk #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 9,
  parameter int OFS_W  = 8,
  parameter int CNT_W  = 9
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              load_fire,
  input logic              rb_fire,
  input logic [1:0]        wr_sel,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  fill_count,
  input logic              almost_empty_n,
  input logic              almost_full_n
);

  // R2
  load_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    load_fire |=> wr_sel == $past(wr_sel) + 2'd1);

  // R3
  load_idle_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !load_fire |=> $stable(wr_sel));

  // R5
  rb_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rb_fire |=> (rd_sel == $past(rd_sel) + 2'd1) && (rd_data[DATA_W-1:OFS_W] == '0));

  // R6
  rb_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rb_fire |=> $stable(rd_data) && $stable(rd_sel));

  // R8
  ae_at_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fill_count == '0) |=> !almost_empty_n);

  // R9
  af_at_depth_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (fill_count == CNT_W'(DEPTH)) |=> !almost_full_n);

endmodule

bind pflag_offset_loader pflag_offset_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .OFS_W(OFS_W), .CNT_W(CNT_W)
) u_chk (
  .wr_clk        (wr_clk),
  .rd_clk        (rd_clk),
  .rst_n         (rst_n),
  .load_fire     (load_fire),
  .rb_fire       (rb_fire),
  .wr_sel        (wr_sel),
  .rd_sel        (rd_sel),
  .rd_data       (rd_data),
  .fill_count    (fill_count),
  .almost_empty_n(almost_empty_n),
  .almost_full_n (almost_full_n)
);

// File: tb/tb_pflag_offset_loader.sv
module tb_pflag_offset_loader;

  localparam int DEPTH = 256;

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_n = 1'b1;
  logic       ld_n = 1'b1;
  logic       rd_en1_n = 1'b1;
  logic       rd_en2_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] fill_count = 9'd100;
  logic [8:0] rd_data;
  logic       almost_empty_n;
  logic       almost_full_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [7:0] m_reg [4];
  int m_wp;
  int m_rp;

  always #2 wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;

  pflag_offset_loader dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .ld_n(ld_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .wr_data(wr_data), .fill_count(fill_count), .rd_data(rd_data),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) m_reg[i] = 8'd7;
    m_wp = 0;
    m_rp = 0;
    @(negedge wr_clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [8:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0; ld_n = 1'b0; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1; ld_n = 1'b1;
    m_reg[m_wp] = d[7:0];
    m_wp = (m_wp + 1) % 4;
  endtask

  task automatic readback(input string req);
    @(negedge rd_clk);
    ld_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk);
    ld_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    chk(req, rd_data, {1'b0, m_reg[m_rp]});
    m_rp = (m_rp + 1) % 4;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 4; i++) readback(req);
  endtask

  task automatic flags_at(input int cnt, input string req);
    @(negedge wr_clk);
    fill_count = 9'(cnt);
    @(negedge wr_clk);
    chk({req, " ae"}, almost_empty_n, (cnt <= int'(m_reg[0])) ? 0 : 1);
    chk({req, " af"}, almost_full_n, ((DEPTH - cnt) <= int'(m_reg[2])) ? 0 : 1);
  endtask

  // R1: values held during reset and defaults after it
  task automatic t_reset();
    @(negedge wr_clk);
    rst_n = 1'b0;
    @(negedge wr_clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 almost_empty_n", almost_empty_n, 0);
    chk("R1 almost_full_n", almost_full_n, 1);
    do_reset();
    sweep("R1 default offset");
  endtask

  // R5: fifth readback wraps to the empty-low slot
  task automatic t_rb_wrap();
    load(9'h011);
    readback("R5 wrap to empty-low");
    sweep("R5 rotation");
  endtask

  // R2: five loads in a row, fifth wraps
  task automatic t_load_order();
    do_reset();
    load(9'h0A1); load(9'h0B2); load(9'h0C3); load(9'h0D4); load(9'h0E5);
    sweep("R2 load order");
  endtask

  // R4: pause between partial loads
  task automatic t_partial();
    load(9'h021);
    repeat (5) @(negedge wr_clk);
    load(9'h032);
    repeat (3) @(negedge wr_clk);
    load(9'h043);
    sweep("R4 resume");
  endtask

  // R3: one strobe alone does nothing
  task automatic t_gate();
    @(negedge wr_clk);
    wr_en_n = 1'b0; ld_n = 1'b1; wr_data = 9'h05A;
    @(negedge wr_clk);
    wr_en_n = 1'b1; ld_n = 1'b0; wr_data = 9'h06B;
    @(negedge wr_clk);
    ld_n = 1'b1;
    sweep("R3 gated");
    load(9'h077);
    sweep("R3 pointer kept");
  endtask

  // R7: data bit 8 dropped
  task automatic t_bit8();
    load(9'h1AA);
    load(9'h155);
    sweep("R7 bit8 ignored");
  endtask

  // R6: partial read conditions hold rd_data
  task automatic t_hold();
    logic [8:0] held;
    readback("R6 setup");
    held = rd_data;
    @(negedge rd_clk);
    ld_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b1;
    @(negedge rd_clk);
    chk("R6 one enable", rd_data, held);
    ld_n = 1'b1; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk);
    chk("R6 ld high", rd_data, held);
    ld_n = 1'b0; rd_en1_n = 1'b1; rd_en2_n = 1'b0;
    @(negedge rd_clk);
    chk("R6 other enable", rd_data, held);
    ld_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    readback("R6 pointer kept");
  endtask

  // R8, R9: threshold boundaries
  task automatic t_flags();
    do_reset();
    load(9'd10); load(9'd0); load(9'd20); load(9'd0);
    flags_at(9, "R8");
    flags_at(10, "R8");
    flags_at(11, "R8");
    flags_at(0, "R8");
    flags_at(235, "R9");
    flags_at(236, "R9");
    flags_at(237, "R9");
    flags_at(256, "R9");
  endtask

  // R10: high registers do not move the flags
  task automatic t_msb();
    load(9'd10); load(9'h0FF); load(9'd20); load(9'h0FF);
    sweep("R10 stored");
    flags_at(10, "R10");
    flags_at(11, "R10");
    flags_at(235, "R10");
    flags_at(236, "R10");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    t_reset();
    t_rb_wrap();
    t_load_order();
    t_partial();
    t_gate();
    t_bit8();
    t_hold();
    t_flags();
    t_msb();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

endmodule